// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block makes one pulse-width-modulated output. Software drives it through a small 32-bit register bus with an address, a write strobe, write data and combinational read data. A compare value sets the duty cycle, and software never writes that value directly. Each write to the sample register goes into a four-word queue. The running modulator takes the oldest queued word when a period starts. Software can therefore stage several duty values ahead, and each one takes effect cleanly on a period edge.

A prescaler divides the system clock by a programmable ratio. A period counter then steps once per prescaled tick, and every period spans two more ticks than the programmed period value. A control register holds the enable, the prescaler ratio, a clock-source code, an output inversion bit, three stored-only flags and a self-clearing software reset. The status register reports how many queue words are filled.

Top module: `pwm_sample_queue`

## Requirements
- R1: The control register at offset 0x00 reads back what was written. Bit 0 is the enable, bits 15:4 are the prescaler field, bits 17:16 are the clock-source code, bit 18 is the inversion bit, and bits 24:22 are stored flags. All other bits read as zero, except bit 3 (see R8).
- R2: A write to offset 0x0C adds the low 16 data bits to a 4-word FIFO. Status bits 2:0 at offset 0x04 give the number of filled words. A write while 4 words are filled is discarded.
- R3: A period starts on the first cycle after the modulator begins running and on every counter rollover. At each period start the oldest FIFO word becomes the active compare value, which is read at offset 0x0C. If the FIFO is empty, the previous compare value stays active.
- R4: With prescaler field N and period register P at offset 0x10, one period lasts (P+2)*(N+1) clock cycles.
- R5: With the inversion bit clear, the output is high for min(C, P+2)*(N+1) cycles of each period, where C is the active compare value. A value of 0 keeps it low all the time, and a value of P+2 or more keeps it high all the time.
- R6: Setting the inversion bit inverts the output in every state, including the idle level.
- R7: The modulator stops when the enable is 0, and also when the clock-source code is 0 or 3. Codes 1 and 2 both run from the system clock. While stopped, the counter does not advance, no FIFO word is taken, and the output sits at the idle level, which equals the inversion bit.
- R8: Writing 1 to control bit 3 starts a software reset. The reset zeroes every register and the compare value, empties the FIFO and drives the output low. Bit 3 reads 1 for 4 cycles and then clears. Register writes made while it reads 1 are ignored.
- R9: Control bits 24:22 have no effect on the output.
- R10: After the asynchronous reset, every register reads zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest thing to reach from the ports is the exact cycle on which the queue advances. That cycle falls a full prescaled period after the first take, and nothing reaches the pins when it happens. The bench fills the queue while the modulator is stopped and starts it with a single control write. It then reads the active compare value exactly one cycle before and one cycle after each predicted rollover, with the prescaler both at 1 and at 3. Dropping a sample on a full queue is exposed by the same method: the sequence stops at the fourth word.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_SAMPLE = 'h0C;
  localparam int OFS_PERIOD = 'h10;

  localparam int PSC_W      = 12;
  localparam int BIT_EN     = 0;
  localparam int BIT_SRST   = 3;
  localparam int PSC_LSB    = 4;
  localparam int CSEL_LSB   = 16;
  localparam int BIT_POL    = 18;
  localparam int FLAG_LSB   = 22;

  typedef struct packed {
    logic [2:0]       flags;
    logic             pol;
    logic [1:0]       csel;
    logic [PSC_W-1:0] presc;
    logic             en;
  } ctrl_t;

endpackage

// File: rtl/pwmq_rst_sync.sv
module pwmq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW    = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [FW-1:0]    fill_q, fill_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (fill_q != FW'(DEPTH));
  assign pop_ok  = pop && (fill_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      fill_d   = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      fill_d = fill_q + FW'(push_ok) - FW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr_q] <= din;
  end

  assign head = mem[rd_ptr_q];
  assign fill = fill_q;
endmodule

// File: rtl/pwmq_timebase.sv
module pwmq_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] presc,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W:0]   cnt,
  output logic             wrap
);
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W:0]   cnt_q, cnt_d;
  logic [CNT_W:0]   last_val;
  logic             tick;

  assign last_val = {1'b0, period} + (CNT_W+1)'(1);
  assign tick     = (psc_q == presc);
  assign wrap     = run && tick && (cnt_q == last_val);

  always_comb begin
    psc_d = psc_q;
    cnt_d = cnt_q;
    if (!run) begin
      psc_d = '0;
      cnt_d = '0;
    end else begin
      psc_d = tick ? '0 : psc_q + 1'b1;
      if (tick) cnt_d = (cnt_q == last_val) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else begin
      psc_q <= psc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_sample_queue.sv
module pwm_sample_queue #(
  parameter int DEPTH       = 4,
  parameter int CNT_W       = 16,
  parameter int SRST_CYCLES = 4,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  import pwmq_pkg::*;

  localparam int FW   = $clog2(DEPTH+1);
  localparam int SC_W = $clog2(SRST_CYCLES+1);

  logic              rst_sync_n;
  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  period_q, period_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [SC_W-1:0]   srst_cnt_q, srst_cnt_d;
  logic              started_q, started_d;
  logic              pwm_q, pwm_d;
  logic              srst_busy, srst_go;
  logic              wr_ctrl, wr_samp, wr_per;
  logic              run, pop_evt, wrap, active;
  logic [CNT_W-1:0]  fifo_head;
  logic [FW-1:0]     fifo_fill;
  logic [CNT_W:0]    tb_cnt;

  pwmq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign srst_busy = (srst_cnt_q != '0);
  assign wr_ctrl   = bus_we && !srst_busy && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_samp   = bus_we && !srst_busy && (bus_addr == ADDR_W'(OFS_SAMPLE));
  assign wr_per    = bus_we && !srst_busy && (bus_addr == ADDR_W'(OFS_PERIOD));
  assign srst_go   = wr_ctrl && bus_wdata[BIT_SRST];

  assign run     = ctrl_q.en && (ctrl_q.csel == 2'd1 || ctrl_q.csel == 2'd2) && !srst_busy;
  assign pop_evt = run && (!started_q || wrap);

  pwmq_fifo #(.DEPTH(DEPTH), .W(CNT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .flush (srst_go),
    .push  (wr_samp),
    .din   (bus_wdata[CNT_W-1:0]),
    .pop   (pop_evt),
    .head  (fifo_head),
    .fill  (fifo_fill)
  );

  pwmq_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (run && started_q),
    .presc  (ctrl_q.presc),
    .period (period_q),
    .cnt    (tb_cnt),
    .wrap   (wrap)
  );

  assign active = run && started_q && (tb_cnt < {1'b0, cmp_q});

  always_comb begin
    ctrl_d     = ctrl_q;
    period_d   = period_q;
    cmp_d      = cmp_q;
    srst_cnt_d = srst_cnt_q;
    started_d  = run;
    pwm_d      = ctrl_q.pol ^ active;
    if (pop_evt && fifo_fill != '0) cmp_d = fifo_head;
    if (srst_go) begin
      ctrl_d     = '0;
      period_d   = '0;
      cmp_d      = '0;
      started_d  = 1'b0;
      srst_cnt_d = SC_W'(SRST_CYCLES);
      pwm_d      = 1'b0;
    end else if (srst_busy) begin
      srst_cnt_d = srst_cnt_q - 1'b1;
      pwm_d      = 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_d.en    = bus_wdata[BIT_EN];
        ctrl_d.presc = bus_wdata[PSC_LSB +: PSC_W];
        ctrl_d.csel  = bus_wdata[CSEL_LSB +: 2];
        ctrl_d.pol   = bus_wdata[BIT_POL];
        ctrl_d.flags = bus_wdata[FLAG_LSB +: 3];
      end
      if (wr_per) period_d = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q     <= '0;
      period_q   <= '0;
      cmp_q      <= '0;
      srst_cnt_q <= '0;
      started_q  <= 1'b0;
      pwm_q      <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      period_q   <= period_d;
      cmp_q      <= cmp_d;
      srst_cnt_q <= srst_cnt_d;
      started_q  <= started_d;
      pwm_q      <= pwm_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[BIT_EN]               = ctrl_q.en;
        bus_rdata[BIT_SRST]             = srst_busy;
        bus_rdata[PSC_LSB +: PSC_W]     = ctrl_q.presc;
        bus_rdata[CSEL_LSB +: 2]        = ctrl_q.csel;
        bus_rdata[BIT_POL]              = ctrl_q.pol;
        bus_rdata[FLAG_LSB +: 3]        = ctrl_q.flags;
      end
      ADDR_W'(OFS_STATUS): bus_rdata = 32'(fifo_fill);
      ADDR_W'(OFS_SAMPLE): bus_rdata = 32'(cmp_q);
      ADDR_W'(OFS_PERIOD): bus_rdata = 32'(period_q);
      default:             bus_rdata = '0;
    endcase
  end

  assign pwm_out = pwm_q;
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic                       push,
  input logic                       pop,
  input logic [CNT_W-1:0]           cmp,
  input logic                       busy,
  input logic                       run,
  input logic                       pol,
  input logic                       pwm_out
);
  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH)); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == ($clog2(DEPTH+1))'(DEPTH) && push && !pop && !busy) |=> (busy || fill == ($clog2(DEPTH+1))'(DEPTH))); // R2

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fill == '0) |=> (busy || $stable(cmp))); // R3

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pwm_out); // R8

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !busy) |=> (busy || pwm_out == $past(pol))); // R7

  AST_POP_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> run); // R7
endmodule

bind pwm_sample_queue pwmq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .fill    (fifo_fill),
  .push    (wr_samp),
  .pop     (pop_evt),
  .cmp     (cmp_q),
  .busy    (srst_busy),
  .run     (run),
  .pol     (ctrl_q.pol),
  .pwm_out (pwm_out)
);

// File: tb/pwm_sample_queue_test.sv
module pwm_sample_queue_test;
  localparam int TCK  = 10;
  localparam int SRST = 4;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

  logic        clk, rst_n, bus_we, pwm_out;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  pwm_sample_queue uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial clk = 0;
  always #(TCK/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 32'h8);
    repeat (SRST + 1) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input int en, input int psc, input int cs, input int pol, input int fl);
    return 32'(en) | (32'(psc) << 4) | (32'(cs) << 16) | (32'(pol) << 18) | (32'(fl) << 22);
  endfunction

  task automatic t_reset_state();
    logic [31:0] v;
    rd(A_CTRL, v); check("R10 ctrl", v, 0);
    rd(A_STAT, v); check("R10 status", v, 0);
    rd(A_SAMP, v); check("R10 sample", v, 0);
    rd(A_PER, v);  check("R10 period", v, 0);
    check("R10 out", pwm_out, 0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    wr(A_CTRL, ctl(0, 'hABC, 2, 1, 7) | 32'hFE38_0006);
    rd(A_CTRL, v); check("R1 ctrl readback", v, ctl(0, 'hABC, 2, 1, 7));
    soft_reset();
  endtask

  task automatic t_fifo_order();
    logic [31:0] v;
    soft_reset();
    wr(A_PER, 6);
    wr(A_SAMP, 10); wr(A_SAMP, 20); wr(A_SAMP, 30);
    rd(A_STAT, v); check("R2 fill 3", v, 3);
    wr(A_CTRL, ctl(1, 0, 1, 0, 0));
    @(negedge clk);
    rd(A_SAMP, v); check("R3 first take", v, 10);
    rd(A_STAT, v); check("R2 fill 2", v, 2);
    repeat (7) @(negedge clk);
    rd(A_SAMP, v); check("R4 not yet rolled", v, 10);
    @(negedge clk);
    rd(A_SAMP, v); check("R3 second take", v, 20);
    repeat (8) @(negedge clk);
    rd(A_SAMP, v); check("R3 third take", v, 30);
    rd(A_STAT, v); check("R2 fill 0", v, 0);
    repeat (8) @(negedge clk);
    rd(A_SAMP, v); check("R3 empty keeps", v, 30);
  endtask

  task automatic t_full_drop();
    logic [31:0] v;
    soft_reset();
    wr(A_PER, 2);
    for (int i = 0; i < 5; i++) wr(A_SAMP, 5 + i);
    rd(A_STAT, v); check("R2 full", v, 4);
    wr(A_CTRL, ctl(1, 0, 1, 0, 0));
    @(negedge clk);
    rd(A_SAMP, v); check("R3 take 5", v, 5);
    for (int i = 1; i < 4; i++) begin
      repeat (4) @(negedge clk);
      rd(A_SAMP, v); check("R2 order", v, 5 + i);
    end
    repeat (4) @(negedge clk);
    rd(A_SAMP, v); check("R2 fifth dropped", v, 8);
    rd(A_STAT, v); check("R2 drained", v, 0);
  endtask

  task automatic t_presc_period();
    logic [31:0] v;
    soft_reset();
    wr(A_PER, 2);
    wr(A_SAMP, 3); wr(A_SAMP, 4);
    wr(A_CTRL, ctl(1, 2, 1, 0, 0));
    @(negedge clk);
    rd(A_SAMP, v); check("R4 first", v, 3);
    repeat (11) @(negedge clk);
    rd(A_SAMP, v); check("R4 before 12", v, 3);
    @(negedge clk);
    rd(A_SAMP, v); check("R4 at 12", v, 4);
  endtask

  task automatic t_duty(input string req, input int per, input int s, input int psc,
                        input int pol, input int fl, input int cs);
    int len, hi, on, exp;
    soft_reset();
    wr(A_PER, per);
    wr(A_SAMP, s);
    wr(A_CTRL, ctl(1, psc, cs, pol, fl));
    len = (per + 2) * (psc + 1);
    repeat (2 * len + 3) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 3 * len; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    on  = ((s < per + 2) ? s : per + 2) * (psc + 1);
    exp = pol ? 3 * (len - on) : 3 * on;
    check(req, hi, exp);
  endtask

  task automatic t_stopped();
    logic [31:0] v;
    soft_reset();
    wr(A_SAMP, 5);
    wr(A_CTRL, ctl(1, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(A_STAT, v); check("R7 source 0 no take", v, 1);
    check("R7 source 0 idle", pwm_out, 0);
    wr(A_CTRL, ctl(1, 0, 3, 0, 0));
    repeat (20) @(negedge clk);
    rd(A_STAT, v); check("R7 source 3 no take", v, 1);
    wr(A_CTRL, ctl(0, 0, 1, 1, 0));
    repeat (3) @(negedge clk);
    check("R6 inverted idle", pwm_out, 1);
    rd(A_STAT, v); check("R7 disabled no take", v, 1);
    rd(A_SAMP, v); check("R7 compare unchanged", v, 0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    soft_reset();
    wr(A_PER, 7);
    wr(A_SAMP, 4); wr(A_SAMP, 6); wr(A_SAMP, 2);
    wr(A_CTRL, ctl(1, 1, 2, 1, 5));
    repeat (30) @(negedge clk);
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v); check("R8 bit reads 1", v, 32'h8);
    check("R8 out low", pwm_out, 0);
    wr(A_PER, 9);
    repeat (2) @(negedge clk);
    rd(A_CTRL, v); check("R8 self clear", v, 0);
    rd(A_PER, v);  check("R8 write ignored", v, 0);
    rd(A_STAT, v); check("R8 fifo flushed", v, 0);
    rd(A_SAMP, v); check("R8 compare zero", v, 0);
    check("R8 out after", pwm_out, 0);
  endtask

  initial begin
    #(TCK * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_ctrl_fields();
    t_fifo_order();
    t_full_drop();
    t_presc_period();
    t_duty("R5 duty 3 of 10",       8, 3, 0, 0, 0, 1);
    t_duty("R9 flags no effect",    8, 3, 2, 0, 7, 2);
    t_duty("R6 inverted duty",      8, 3, 2, 1, 0, 1);
    t_duty("R5 compare above span", 4, 20, 0, 0, 0, 1);
    t_duty("R5 compare zero",       4, 0, 0, 0, 0, 1);
    t_duty("R6 inverted zero",      4, 0, 0, 1, 0, 2);
    t_stopped();
    t_srst();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule